// File: doc/BRIEF.md
# Interrupt Cause and Mask Register Bank

This block holds the interrupt state of a host bridge. A 32-bit cause register collects hardware events. Each event input sets its own cause bit, and the bit stays set until software clears it. Software clears cause bits by writing the register with a 0 in each bit it wants cleared and a 1 in each bit it wants kept. Bit 0 of the cause register cannot be written. It always reads as the OR of bits 31 to 1, so one bit tells software whether anything is pending.

Three mask registers sit next to the cause register:

- The CPU mask decides which cause bits raise the registered CPU interrupt output.
- The PCI mask decides which cause bits raise the PCI interrupt output, which follows the cause register with no added register.
- The system-error mask is stored and read back only.

Each mask register keeps only its own pattern of writable bits. The other bits always read as zero.

Top module: `irq_cause_bank`

## Requirements
- R1: A write with `wr_sel`=0 clears each cause bit [31:1] whose written data bit is 0 and keeps each bit whose data bit is 1.
- R2: Reading with `rd_sel`=0 returns in bit 0 the OR of cause bits [31:1]. Data written to bit 0 has no effect.
- R3: A write with `wr_sel`=1 loads the CPU mask with the written data ANDed with 0x3C3FFFFE. A read with `rd_sel`=1 returns the CPU mask.
- R4: A write with `wr_sel`=2 loads the PCI mask with the written data ANDed with 0x03FFFFFE. A read with `rd_sel`=2 returns the PCI mask.
- R5: A write with `wr_sel`=3 loads the system-error mask with data bits [5:0], with the upper bits zero. A read with `rd_sel`=3 returns the system-error mask.
- R6: While `rst_n` is low, all four registers read as zero and both interrupt outputs are low.
- R7: A 1 on `evt[i]` at a clock edge sets cause bit i. If the same edge also carries a software clear of bit i, the bit ends set.
- R8: `cpu_irq` equals, one clock after the cause and CPU mask values it is computed from, the OR over bits [31:1] of cause AND CPU mask.
- R9: `pci_irq` equals, in the same cycle, the OR over bits [31:1] of cause AND PCI mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 cause, 1 CPU mask, 2 PCI mask, 3 system-error mask |
| wr_data | input | 32 | Write data |
| evt | input | 31 | Hardware event pulses for cause bits [31:1] |
| rd_sel | input | 2 | Read select, same encoding as `wr_sel` |
| rd_data | output | 32 | Selected register value, combinational |
| cpu_irq | output | 1 | Registered CPU interrupt |
| pci_irq | output | 1 | PCI interrupt |

## Verification
Random writes to all four registers are mixed with sparse random event vectors, and a bench model checks every register and both outputs after each cycle. This separates the clear-on-zero behaviour from a plain load or a clear-on-one behaviour. Directed cases cover:

- A write of all ones to the cause register, which must leave it unchanged.
- An event and a clear of the same bit in one cycle, which separates set-wins from clear-wins.
- Mask writes of all ones, which expose any bit outside each writable pattern.
- A cause bit that is set with the CPU mask already open, which shows the one-cycle lag of `cpu_irq` against the immediate `pci_irq`.

// File: rtl/irq_cause_bank.sv
module irq_cause_bank #(
  parameter int          W         = 32,
  parameter logic [31:0] CPU_WMASK = 32'h3C3F_FFFE,
  parameter logic [31:0] PCI_WMASK = 32'h03FF_FFFE,
  parameter int          SERR_BITS = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:1] evt,
  input  logic [1:0]   rd_sel,
  output logic [W-1:0] rd_data,
  output logic         cpu_irq,
  output logic         pci_irq
);
  localparam logic [W-1:0] SERR_WMASK = W'((64'd1 << SERR_BITS) - 1);

  logic [W-1:1] cause_q;
  logic [W-1:0] cpu_mask_q, pci_mask_q, serr_mask_q;
  logic [W-1:1] keep;
  logic         summary;

  assign keep    = (wr_en && wr_sel == 2'd0) ? wr_data[W-1:1] : '1;
  assign summary = |cause_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q     <= '0;
      cpu_mask_q  <= '0;
      pci_mask_q  <= '0;
      serr_mask_q <= '0;
      cpu_irq     <= 1'b0;
    end else begin
      cause_q <= (cause_q & keep) | evt;
      if (wr_en && wr_sel == 2'd1) cpu_mask_q  <= wr_data & CPU_WMASK[W-1:0];
      if (wr_en && wr_sel == 2'd2) pci_mask_q  <= wr_data & PCI_WMASK[W-1:0];
      if (wr_en && wr_sel == 2'd3) serr_mask_q <= wr_data & SERR_WMASK;
      cpu_irq <= |(cause_q & cpu_mask_q[W-1:1]);
    end
  end

  assign pci_irq = |(cause_q & pci_mask_q[W-1:1]);

  always_comb begin
    unique case (rd_sel)
      2'd0:    rd_data = {cause_q, summary};
      2'd1:    rd_data = cpu_mask_q;
      2'd2:    rd_data = pci_mask_q;
      default: rd_data = serr_mask_q;
    endcase
  end
endmodule

module irq_cause_bank_chk #(
  parameter int          W         = 32,
  parameter logic [31:0] CPU_WMASK = 32'h3C3F_FFFE,
  parameter logic [31:0] PCI_WMASK = 32'h03FF_FFFE
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic [1:0]   wr_sel,
  input logic [W-1:0] wr_data,
  input logic [W-1:1] evt,
  input logic [1:0]   rd_sel,
  input logic [W-1:0] rd_data,
  input logic         cpu_irq,
  input logic         pci_irq,
  input logic [W-1:1] cause_q,
  input logic [W-1:0] cpu_mask_q
);
  // R1
  cause_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd0 && evt == '0) |=> cause_q == $past(cause_q & wr_data[W-1:1]));

  // R2
  summary_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel == 2'd0) |-> rd_data[0] == (rd_data[W-1:1] != '0));

  // R3
  cpu_mask_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel == 2'd1) |-> (rd_data & ~CPU_WMASK[W-1:0]) == '0);

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cause_q & $past(evt)) == $past(evt));

  // R8
  cpu_irq_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cpu_irq == $past((cause_q & cpu_mask_q[W-1:1]) != '0));

  // R9
  pci_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_q == '0) |-> !pci_irq);
endmodule

bind irq_cause_bank irq_cause_bank_chk #(
  .W(W), .CPU_WMASK(CPU_WMASK), .PCI_WMASK(PCI_WMASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .evt(evt), .rd_sel(rd_sel), .rd_data(rd_data), .cpu_irq(cpu_irq),
  .pci_irq(pci_irq), .cause_q(cause_q), .cpu_mask_q(cpu_mask_q)
);

// File: tb/tb_irq_cause_bank.sv
`timescale 1ns/1ps
module tb_irq_cause_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [31:1] evt = '0;
  logic [1:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic        cpu_irq, pci_irq;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:1] m_cause = '0;
  logic [31:0] m_cpu = '0, m_pci = '0, m_serr = '0;
  logic        m_cpu_irq = 1'b0;

  always #4 clk = ~clk;

  irq_cause_bank dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_cause();
    return {m_cause, |m_cause};
  endfunction

  task automatic read_all();
    rd_sel = 2'd0; #0.5; check("R1/R2 cause", rd_data, exp_cause());
    rd_sel = 2'd1; #0.5; check("R3 cpu mask", rd_data, m_cpu);
    rd_sel = 2'd2; #0.5; check("R4 pci mask", rd_data, m_pci);
    rd_sel = 2'd3; #0.5; check("R5 serr mask", rd_data, m_serr);
    check("R8 cpu_irq", {31'd0, cpu_irq}, {31'd0, m_cpu_irq});
    check("R9 pci_irq", {31'd0, pci_irq}, {31'd0, |(m_cause & m_pci[31:1])});
  endtask

  task automatic step(bit we, logic [1:0] sel, logic [31:0] data, logic [31:1] ev);
    wr_en = we; wr_sel = sel; wr_data = data; evt = ev;
    m_cpu_irq = |(m_cause & m_cpu[31:1]);
    m_cause = (m_cause & ((we && sel == 2'd0) ? data[31:1] : '1)) | ev;
    if (we && sel == 2'd1) m_cpu  = data & 32'h3C3F_FFFE;
    if (we && sel == 2'd2) m_pci  = data & 32'h03FF_FFFE;
    if (we && sel == 2'd3) m_serr = data & 32'h0000_003F;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; evt = '0;
    read_all();
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed = $urandom(32'h1CE5);
    seed = seed;
    // R6 reset: drive writes during reset, all must stay zero
    wr_en = 1'b1; wr_sel = 2'd1; wr_data = '1; evt = '1;
    repeat (3) @(negedge clk);
    read_all();
    wr_en = 1'b0; evt = '0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    read_all();

    // R2: writing ones to cause has no effect on empty or full register
    step(1, 2'd0, 32'hFFFF_FFFF, '0);
    check("R2 bit0 idle", exp_cause(), 32'd0);
    // R3/R4/R5: all-ones mask writes expose writable patterns
    step(1, 2'd1, 32'hFFFF_FFFF, '0);
    check("R3 pattern", m_cpu, 32'h3C3F_FFFE);
    step(1, 2'd2, 32'hFFFF_FFFF, '0);
    step(1, 2'd3, 32'hFFFF_FFFF, '0);
    // R7/R8/R9: event with masks open, cpu_irq lags one cycle
    step(0, 2'd0, '0, 31'(32'h0000_0010 >> 1));
    check("R9 pci same cycle", {31'd0, pci_irq}, 32'd1);
    check("R8 cpu lag", {31'd0, cpu_irq}, 32'd0);
    step(0, 2'd0, '0, '0);
    check("R8 cpu after lag", {31'd0, cpu_irq}, 32'd1);
    // R1: clear bit 4 with a zero, keep the rest
    step(0, 2'd0, '0, 31'(32'h8000_0100 >> 1));
    step(1, 2'd0, 32'hFFFF_FFEF, '0);
    check("R1 cleared bit4", exp_cause(), 32'h8000_0101);
    // R7: set and clear of bit 8 in the same cycle, set wins
    step(1, 2'd0, 32'h0000_0000, 31'(32'h0000_0100 >> 1));
    check("R7 set wins", exp_cause(), 32'h0000_0101);
    // R2: write bit0 alone with zeros elsewhere clears all
    step(1, 2'd0, 32'h0000_0001, '0);
    check("R2 bit0 write ignored", exp_cause(), 32'd0);

    for (int i = 0; i < 400; i++) begin
      logic [31:1] ev;
      ev = ($urandom % 4 == 0) ? 31'(($urandom & $urandom & $urandom) >> 1) : '0;
      step($urandom % 2 == 0, 2'($urandom), $urandom, ev);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule